// File: doc/BRIEF.md
# Shared-Memory Link Handshake Initiator

This block brings up a mailbox link between the local processor and a remote one that share a small descriptor region in memory. After a start pulse it reads the region through a single 32-bit register master port. It checks an identification word and a format version, and it picks up the offset and size of the local outbound mailbox. It then acknowledges the peer's current link state.

Next it runs three fixed handshake stages. In each stage it writes the "up" state word (0x0000FFFF) into one field and rings the peer with a one-cycle doorbell pulse. It then polls another field until the peer shows "up" there. Polling is bounded in both the number of tries and the spacing between reads.

The result is a `ready` level on success, or a 3-bit error code naming the cause. The message path that uses the mailbox afterwards is handled elsewhere.

Top module: `shm_link_init`

## Requirements
- R1: After reset, `ready`, `busy`, `doorbell` and `bus_req` are low and `err_code` is 0.
- R2: A `start` pulse while not busy clears `ready` and `err_code` and restarts the sequence from the first read. A `start` pulse while busy is ignored.
- R3: The word at byte offset 0x00 must equal 0x4D41494C and the word at 0x04 must equal 1. On any mismatch the block stops with `err_code` 1, without issuing any write or doorbell.
- R4: The mailbox size is read from offset 0x34 and the mailbox offset from 0x38; both are presented on `mbox_size` and `mbox_offset`. A size of zero stops the block with `err_code` 2 and no doorbell.
- R5: The word read at 0x0C, which is the peer link state, is written unchanged to 0x10 before the first doorbell.
- R6: Stage 1 writes 0x0000FFFF to 0x24, pulses the doorbell, then polls 0x28 for 0x0000FFFF.
- R7: Stage 2 writes 0x0000FFFF to 0x2C, pulses the doorbell, then polls 0x14 for 0x0000FFFF.
- R8: Stage 3 writes 0x0000FFFF to 0x18, pulses the doorbell, then polls 0x30 for 0x0000FFFF.
- R9: Each doorbell is exactly one cycle long. A successful run produces exactly three doorbells, one per stage.
- R10: Each stage reads its poll field at most POLL_TRIES times, and consecutive reads are at least POLL_INTERVAL cycles apart. If the tries run out, the block stops with `err_code` 3, 4 or 5 for stage 1, 2 or 3.
- R11: When the stage 3 poll reads "up", `ready` goes high with `err_code` 0 and `busy` low. `ready` stays high until the next accepted start.
- R12: At most one access is outstanding. Once `bus_req` is raised, it stays high with a steady address, direction and write data until `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the bring-up sequence (single-cycle pulse) |
| bus_req | output | 1 | Access request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Byte offset into the descriptor region |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access complete; read data valid in this cycle |
| bus_rdata | input | 32 | Read data |
| doorbell | output | 1 | One-cycle notification to the peer |
| busy | output | 1 | Sequence in progress |
| ready | output | 1 | Link and channel are up |
| err_code | output | 3 | 0 none, 1 bad id/version, 2 zero size, 3..5 stage 1..3 timeout |
| mbox_offset | output | 32 | Outbound mailbox offset read from the descriptor |
| mbox_size | output | 32 | Outbound mailbox size read from the descriptor |

## Verification
The assertions assume that the peer raises `bus_ack` for exactly one cycle per request and only while `bus_req` is high. They also assume that read data is valid in the acknowledge cycle and that `start` is a single-cycle pulse. The bench's peer model registers its acknowledge one cycle after each request and never acknowledges twice, and every start is driven for exactly one clock. Peer responses to doorbells are written into the modelled region after a chosen delay, or withheld per stage to force the timeout paths.

// File: rtl/shm_link_init.sv
module shm_link_init #(
  parameter int ADDR_W        = 12,
  parameter int POLL_INTERVAL = 1000,
  parameter int POLL_TRIES    = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic [31:0]       bus_rdata,
  output logic              doorbell,
  output logic              busy,
  output logic              ready,
  output logic [2:0]        err_code,
  output logic [31:0]       mbox_offset,
  output logic [31:0]       mbox_size
);

  localparam logic [31:0] ID_WORD  = 32'h4D41494C;
  localparam logic [31:0] FMT_VER  = 32'h0000_0001;
  localparam logic [31:0] UP_WORD  = 32'h0000_FFFF;
  localparam int          IW       = $clog2(POLL_INTERVAL + 1);
  localparam int          TW       = $clog2(POLL_TRIES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ID, S_VER, S_SIZE, S_OFF, S_PLINK, S_PACK,
    S_SET, S_BELL, S_POLL, S_WAIT, S_DONE, S_FAIL
  } state_t;

  state_t        state;
  logic [1:0]    stage;
  logic [TW-1:0] tries;
  logic [IW-1:0] wait_cnt;
  logic [31:0]   peer_link;
  logic [7:0]    set_off, poll_off;

  assign busy     = !(state == S_IDLE || state == S_DONE || state == S_FAIL);
  assign doorbell = (state == S_BELL);

  always_comb begin
    case (stage)
      2'd0:    begin set_off = 8'h24; poll_off = 8'h28; end
      2'd1:    begin set_off = 8'h2C; poll_off = 8'h14; end
      default: begin set_off = 8'h18; poll_off = 8'h30; end
    endcase
  end

  always_comb begin
    bus_req   = 1'b1;
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    case (state)
      S_ID:    bus_addr = ADDR_W'(8'h00);
      S_VER:   bus_addr = ADDR_W'(8'h04);
      S_SIZE:  bus_addr = ADDR_W'(8'h34);
      S_OFF:   bus_addr = ADDR_W'(8'h38);
      S_PLINK: bus_addr = ADDR_W'(8'h0C);
      S_PACK:  begin bus_we = 1'b1; bus_addr = ADDR_W'(8'h10); bus_wdata = peer_link; end
      S_SET:   begin bus_we = 1'b1; bus_addr = ADDR_W'(set_off); bus_wdata = UP_WORD; end
      S_POLL:  bus_addr = ADDR_W'(poll_off);
      default: bus_req = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      stage       <= '0;
      tries       <= '0;
      wait_cnt    <= '0;
      peer_link   <= '0;
      ready       <= 1'b0;
      err_code    <= '0;
      mbox_offset <= '0;
      mbox_size   <= '0;
    end else begin
      case (state)
        S_IDLE, S_DONE, S_FAIL:
          if (start) begin
            state    <= S_ID;
            stage    <= '0;
            ready    <= 1'b0;
            err_code <= '0;
          end
        S_ID:
          if (bus_ack) begin
            if (bus_rdata != ID_WORD) begin state <= S_FAIL; err_code <= 3'd1; end
            else state <= S_VER;
          end
        S_VER:
          if (bus_ack) begin
            if (bus_rdata != FMT_VER) begin state <= S_FAIL; err_code <= 3'd1; end
            else state <= S_SIZE;
          end
        S_SIZE:
          if (bus_ack) begin
            mbox_size <= bus_rdata;
            if (bus_rdata == '0) begin state <= S_FAIL; err_code <= 3'd2; end
            else state <= S_OFF;
          end
        S_OFF:
          if (bus_ack) begin
            mbox_offset <= bus_rdata;
            state       <= S_PLINK;
          end
        S_PLINK:
          if (bus_ack) begin
            peer_link <= bus_rdata;
            state     <= S_PACK;
          end
        S_PACK:
          if (bus_ack) state <= S_SET;
        S_SET:
          if (bus_ack) state <= S_BELL;
        S_BELL: begin
          tries <= '0;
          state <= S_POLL;
        end
        S_POLL:
          if (bus_ack) begin
            tries <= tries + 1'b1;
            if (bus_rdata == UP_WORD) begin
              if (stage == 2'd2) begin
                state <= S_DONE;
                ready <= 1'b1;
              end else begin
                stage <= stage + 1'b1;
                state <= S_SET;
              end
            end else if (tries >= TW'(POLL_TRIES - 1)) begin
              state    <= S_FAIL;
              err_code <= 3'd3 + {1'b0, stage};
            end else begin
              wait_cnt <= '0;
              state    <= S_WAIT;
            end
          end
        S_WAIT: begin
          wait_cnt <= wait_cnt + 1'b1;
          if (wait_cnt >= IW'(POLL_INTERVAL - 1)) state <= S_POLL;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R9
  doorbell_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |=> !doorbell);

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

  // R11
  ready_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (err_code == 3'd0 && !busy));

  // R10
  try_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tries <= TW'(POLL_TRIES));

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || ready || err_code != 3'd0));

  // R3
  fail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code == 3'd1 || err_code == 3'd2) |-> (!doorbell && !bus_req));

endmodule

// File: tb/shm_link_init_tb.sv
module shm_link_init_tb;
  localparam int AW = 12, INTV = 20, TRIES = 8;
  localparam logic [31:0] UP = 32'h0000FFFF, DOWN = 32'hFFFF0000;

  logic clk = 0, rst_n = 0, start = 0;
  logic bus_req, bus_we, bus_ack, doorbell, busy, ready;
  logic [AW-1:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata, mbox_offset, mbox_size;
  logic [2:0] err_code;

  always #5 clk = ~clk;

  shm_link_init #(.ADDR_W(AW), .POLL_INTERVAL(INTV), .POLL_TRIES(TRIES)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .doorbell(doorbell), .busy(busy), .ready(ready), .err_code(err_code),
    .mbox_offset(mbox_offset), .mbox_size(mbox_size));

  // peer model
  logic [31:0] mem [0:15];
  logic        poke_en = 0, clr = 0;
  logic [3:0]  poke_idx = 0;
  logic [31:0] poke_val = 0;
  logic [2:0]  resp_mask = 3'b111;
  int          resp_dly = 0;
  int          cyc = 0, bell_cnt, cd, writes, id_reads, poll_cnt, last_rd, min_gap;
  int          resp_stage;
  logic        pack_first, long_pulse, hold_bad, prev_db, prev_req, prev_ack;
  logic [AW-1:0] prev_addr;
  int          checks = 0, errors = 0;

  function automatic int resp_idx(int s);
    return (s == 0) ? 10 : (s == 1) ? 5 : 12;
  endfunction

  assign bus_rdata = mem[bus_addr[5:2]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    prev_db <= doorbell; prev_req <= bus_req; prev_ack <= bus_ack; prev_addr <= bus_addr;
    if (!rst_n) bus_ack <= 0;
    else begin
      bus_ack <= 0;
      if (bus_req && !bus_ack) begin
        bus_ack <= 1;
        if (bus_we) mem[bus_addr[5:2]] <= bus_wdata;
      end
    end
    if (poke_en) mem[poke_idx] <= poke_val;
    if (clr) begin
      bell_cnt <= 0; cd <= 0; writes <= 0; id_reads <= 0; poll_cnt <= 0;
      last_rd <= -1; min_gap <= 1000000; pack_first <= 0; long_pulse <= 0; hold_bad <= 0;
    end else begin
      if (doorbell && prev_db) long_pulse <= 1;
      if (prev_req && !prev_ack && (!bus_req || bus_addr != prev_addr)) hold_bad <= 1;
      if (bus_req && bus_ack) begin
        if (bus_we) begin
          writes <= writes + 1;
          if (bus_addr == AW'(8'h10) && bell_cnt == 0) pack_first <= 1;
        end else if (bus_addr == AW'(8'h00)) id_reads <= id_reads + 1;
        else if (bell_cnt > 0 && bus_addr[5:2] == 4'(resp_idx(bell_cnt-1))) begin
          poll_cnt <= poll_cnt + 1;
          if (last_rd >= 0 && cyc - last_rd < min_gap) min_gap <= cyc - last_rd;
          last_rd <= cyc;
        end
      end
      if (doorbell) begin
        bell_cnt <= bell_cnt + 1;
        poll_cnt <= 0; last_rd <= -1;
        if (resp_mask[bell_cnt]) begin cd <= resp_dly + 1; resp_stage <= bell_cnt; end
      end else if (cd != 0) begin
        cd <= cd - 1;
        if (cd == 1) mem[resp_idx(resp_stage)] <= UP;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(int idx, logic [31:0] v);
    @(negedge clk); poke_en = 1; poke_idx = 4'(idx); poke_val = v;
    @(negedge clk); poke_en = 0;
  endtask

  task automatic setup(logic [31:0] id, logic [31:0] ver, logic [31:0] sz);
    poke(0, id); poke(1, ver); poke(13, sz); poke(14, 32'h0000_0200);
    poke(3, 32'h1234ABCD); poke(4, 0);
    poke(9, DOWN); poke(10, DOWN); poke(11, DOWN); poke(5, DOWN); poke(6, DOWN); poke(12, DOWN);
    @(negedge clk); clr = 1; @(negedge clk); clr = 0;
  endtask

  task automatic run();
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 ready", ready, 0); chk("R1 err", err_code, 0); chk("R1 busy", busy, 0);
    chk("R1 req", bus_req, 0); chk("R1 doorbell", doorbell, 0);
  endtask

  task automatic t_good(int dly);
    resp_mask = 3'b111; resp_dly = dly;
    setup(32'h4D41494C, 1, 32'h40);
    run();
    chk("R11 ready", ready, 1); chk("R11 err", err_code, 0);
    chk("R4 offset", mbox_offset, 32'h200); chk("R4 size", mbox_size, 32'h40);
    chk("R5 copy", mem[4], 32'h1234ABCD); chk("R5 before bell", 32'(pack_first), 1);
    chk("R6 link up", mem[9], UP); chk("R7 chan up", mem[11], UP); chk("R8 peer chan ack", mem[6], UP);
    chk("R9 bells", bell_cnt, 3); chk("R9 pulse", 32'(long_pulse), 0);
    chk("R12 hold", 32'(hold_bad), 0);
  endtask

  task automatic t_bad(logic [31:0] id, logic [31:0] ver, logic [31:0] sz, int exp_err, string tag);
    setup(id, ver, sz);
    run();
    chk({tag, " err"}, err_code, exp_err); chk({tag, " bells"}, bell_cnt, 0);
    chk({tag, " writes"}, writes, 0); chk({tag, " ready"}, ready, 0);
  endtask

  task automatic t_timeout(int s);
    resp_mask = 3'b111 & ~(3'b001 << s); resp_dly = 3;
    setup(32'h4D41494C, 1, 32'h40);
    run();
    chk("R10 err", err_code, 3 + s); chk("R10 ready", ready, 0);
    chk("R10 tries", poll_cnt, TRIES); chk("R10 gap", 32'(min_gap >= INTV), 1);
    chk("R10 bells", bell_cnt, s + 1);
  endtask

  task automatic t_start_busy();
    resp_mask = 3'b111; resp_dly = 30;
    setup(32'h4D41494C, 1, 32'h40);
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    repeat (25) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R2 ignored start id reads", id_reads, 1); chk("R2 ready", ready, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 0;
    clr = 1;
    repeat (3) @(negedge clk);
    rst_n = 1; clr = 0;
    @(negedge clk);
    t_reset();
    t_good(0);
    t_bad(32'h4D41494D, 1, 32'h40, 1, "R3 id");
    t_bad(32'h4D41494C, 2, 32'h40, 1, "R3 version");
    t_bad(32'h4D41494C, 1, 0, 2, "R4 zero size");
    t_timeout(0);
    t_timeout(1);
    t_timeout(2);
    t_good(45);
    t_start_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule